// File: doc/BRIEF.md
# Modular-Exponentiation Accelerator Control Registers

This block is the software-facing register file of a modular-exponentiation accelerator. A CPU reaches it over a simple 32-bit register bus. Through that bus the CPU sets the operand bit lengths, the operating mode, the DMA source address and byte count, and the interrupt masks. It then launches a job by writing the start and DMA-feed controls together. The block turns that launch write into single-cycle pulses for the arithmetic engine and the context loader. It holds every setting steady on dedicated outputs.

Two pulse inputs come back from the datapath. One arrives when the loader has filled the operand memory, and the other when the engine has finished. Each pulse sets its own sticky status flag. Software treats a job as finished only when both flags are set, and it clears them by writing ones. A separate control bit passes the internal operand SRAM between the engine and the CPU, so that the CPU can read the result once the engine is idle.

Top module: `modexp_csr`

## Requirements
- R1: After reset, every register reads zero. `regReady`, `engStart`, `loadStart`, `irq` and `jobDone` are low. `sramEngOwn` is high.
- R2: Each cycle with `regValid` high is one access. `regReady` is high in the following cycle. For a read (`regWe` low), `regRdata` carries the addressed value in that same following cycle and holds it until the next read.
- R3: The start register sits at offset 0x00 and bits 1:0 read back as written. Writing bit 0 = 1 makes `engStart` high for exactly the next cycle. If bit 1 is also 1, `loadStart` pulses in that same cycle. `dmaEnable` follows stored bit 1.
- R4: The configuration register sits at offset 0x48. Bits 5:4 are the mode (2 = elliptic curve, 3 = RSA) and drive `engMode`. Bit 8 is the CPU SRAM grant. All other bits read zero.
- R5: The operand-length register sits at offset 0x58. Bits 31:16 drive `expBits` and bits 15:0 drive `modBits`.
- R6: Offset 0x4C holds the 32-bit DMA source address on `dmaSrc`. Offset 0x50 holds the byte count in bits 15:0 on `dmaLen`, and its upper bits read zero.
- R7: In the status register at offset 0x3FC, a `loadDone` pulse sets bit 2 and an `engDone` pulse sets bit 1. Each bit stays set until it is cleared.
- R8: Writing to offset 0x3FC clears each status bit whose written bit is 1 and leaves the other bits alone. A set pulse in the same cycle wins over the clear.
- R9: The interrupt mask register sits at offset 0x3F8 and uses bits 2 and 1. `irq` is the OR of the status bits ANDed with their mask bits.
- R10: `sramCpuOwn` equals the stored grant bit and `sramEngOwn` is its inverse. Exactly one of the two is high at all times.
- R11: A start write made while the grant bit is set produces no `engStart` or `loadStart` pulse. The start register still stores the written bits.
- R12: A read of any other offset returns zero. A write to any other offset changes no register and no output.
- R13: `jobDone` is high exactly when status bits 2 and 1 are both set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| regValid | input | 1 | Register access in this cycle |
| regWe | input | 1 | 1 = write, 0 = read |
| regAddr | input | 12 | Byte offset of the access |
| regWdata | input | 32 | Write data |
| regRdata | output | 32 | Read data, valid with regReady after a read |
| regReady | output | 1 | Access completed |
| engStart | output | 1 | One-cycle start pulse to the engine |
| loadStart | output | 1 | One-cycle start pulse to the context loader |
| dmaEnable | output | 1 | Stored DMA-feed control bit |
| engMode | output | 2 | Operating mode |
| expBits | output | 16 | Exponent length in bits |
| modBits | output | 16 | Modulus length in bits |
| dmaSrc | output | 32 | DMA source address |
| dmaLen | output | 16 | DMA byte count |
| loadDone | input | 1 | Loader finished pulse |
| engDone | input | 1 | Engine finished pulse |
| sramCpuOwn | output | 1 | CPU owns the operand SRAM |
| sramEngOwn | output | 1 | Engine owns the operand SRAM |
| irq | output | 1 | Masked interrupt |
| jobDone | output | 1 | Both completion flags set |

## Verification
The hardest case to reach from the ports is a done pulse that lands in the same cycle as a write-one-to-clear of the same status bit. In that cycle the set must win. The stimulus aligns a `loadDone` pulse with a status write that clears bit 2, and it reads the register back afterwards. A second case is a launch write made while the CPU holds the SRAM. The bench grants the SRAM first and then writes start with DMA. It expects no pulse but expects the written bits to read back.

// File: rtl/modexp_csr_pkg.sv
package modexp_csr_pkg;

  localparam int CSR_AW = 12;
  localparam int CSR_DW = 32;

  localparam logic [CSR_AW-1:0] OFF_START = 12'h000;
  localparam logic [CSR_AW-1:0] OFF_CFG   = 12'h048;
  localparam logic [CSR_AW-1:0] OFF_SRC   = 12'h04C;
  localparam logic [CSR_AW-1:0] OFF_LEN   = 12'h050;
  localparam logic [CSR_AW-1:0] OFF_OPLEN = 12'h058;
  localparam logic [CSR_AW-1:0] OFF_MASK  = 12'h3F8;
  localparam logic [CSR_AW-1:0] OFF_FLAGS = 12'h3FC;

  localparam int BIT_GRANT = 8;
  localparam int BIT_RDY   = 2;
  localparam int BIT_CMP   = 1;

  typedef struct packed {
    logic wrStart;
    logic wrCfg;
    logic wrSrc;
    logic wrLen;
    logic wrOpLen;
    logic wrMask;
    logic wrFlags;
    logic rdAccess;
  } csrStrobeT;

endpackage

// File: rtl/modexp_csr_ctrl.sv
module modexp_csr_ctrl
  import modexp_csr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              regValid,
  input  logic              regWe,
  input  logic [CSR_AW-1:0] regAddr,
  input  logic [1:0]        startBits,
  input  logic              sramCpuOwn,
  output csrStrobeT         stb,
  output logic              regReady,
  output logic              engStart,
  output logic              loadStart
);

  logic wrAny;
  assign wrAny = regValid && regWe;

  always_comb begin
    stb          = '0;
    stb.wrStart  = wrAny && (regAddr == OFF_START);
    stb.wrCfg    = wrAny && (regAddr == OFF_CFG);
    stb.wrSrc    = wrAny && (regAddr == OFF_SRC);
    stb.wrLen    = wrAny && (regAddr == OFF_LEN);
    stb.wrOpLen  = wrAny && (regAddr == OFF_OPLEN);
    stb.wrMask   = wrAny && (regAddr == OFF_MASK);
    stb.wrFlags  = wrAny && (regAddr == OFF_FLAGS);
    stb.rdAccess = regValid && !regWe;
  end

  logic launchOk;
  assign launchOk = stb.wrStart && startBits[0] && !sramCpuOwn;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      regReady  <= 1'b0;
      engStart  <= 1'b0;
      loadStart <= 1'b0;
    end else begin
      regReady  <= regValid;
      engStart  <= launchOk;
      loadStart <= launchOk && startBits[1];
    end
  end

  // R3: a loader launch never comes without an engine launch
  p_load_with_eng_r3: assert property (@(posedge clk) disable iff (!rst_n)
    loadStart |-> engStart);

endmodule

// File: rtl/modexp_csr_dp.sv
module modexp_csr_dp
  import modexp_csr_pkg::*;
#(
  parameter int SRC_W = 32,
  parameter int LEN_W = 16,
  parameter int OPL_W = 16
)(
  input  logic              clk,
  input  logic              rst_n,
  input  csrStrobeT         stb,
  input  logic [CSR_AW-1:0] regAddr,
  input  logic [CSR_DW-1:0] regWdata,
  input  logic              loadDone,
  input  logic              engDone,
  output logic [CSR_DW-1:0] regRdata,
  output logic              dmaEnable,
  output logic [1:0]        engMode,
  output logic [OPL_W-1:0]  expBits,
  output logic [OPL_W-1:0]  modBits,
  output logic [SRC_W-1:0]  dmaSrc,
  output logic [LEN_W-1:0]  dmaLen,
  output logic              sramCpuOwn,
  output logic              irq,
  output logic              jobDone
);

  logic [1:0] startReg;
  logic       grantReg;
  logic [1:0] maskRdy;
  logic [1:0] flagReg;  // [1] = ready flag, [0] = complete flag
  logic [1:0] maskReg;
  logic [1:0] clrMask;
  logic [1:0] setMask;
  logic [CSR_DW-1:0] rdMux;

  assign maskRdy = {regWdata[BIT_RDY], regWdata[BIT_CMP]};
  assign clrMask = stb.wrFlags ? maskRdy : 2'b00;
  assign setMask = {loadDone, engDone};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      startReg <= '0;
      grantReg <= 1'b0;
      engMode  <= '0;
      expBits  <= '0;
      modBits  <= '0;
      dmaSrc   <= '0;
      dmaLen   <= '0;
      maskReg  <= '0;
      flagReg  <= '0;
    end else begin
      if (stb.wrStart) startReg <= regWdata[1:0];
      if (stb.wrCfg) begin
        grantReg <= regWdata[BIT_GRANT];
        engMode  <= regWdata[5:4];
      end
      if (stb.wrOpLen) begin
        expBits <= regWdata[16 +: OPL_W];
        modBits <= regWdata[OPL_W-1:0];
      end
      if (stb.wrSrc)  dmaSrc  <= regWdata[SRC_W-1:0];
      if (stb.wrLen)  dmaLen  <= regWdata[LEN_W-1:0];
      if (stb.wrMask) maskReg <= maskRdy;
      flagReg <= (flagReg & ~clrMask) | setMask;
    end
  end

  always_comb begin
    rdMux = '0;
    case (regAddr)
      OFF_START: rdMux[1:0] = startReg;
      OFF_CFG: begin
        rdMux[BIT_GRANT] = grantReg;
        rdMux[5:4]       = engMode;
      end
      OFF_OPLEN: rdMux = {expBits, modBits};
      OFF_SRC:   rdMux = CSR_DW'(dmaSrc);
      OFF_LEN:   rdMux = CSR_DW'(dmaLen);
      OFF_MASK: begin
        rdMux[BIT_RDY] = maskReg[1];
        rdMux[BIT_CMP] = maskReg[0];
      end
      OFF_FLAGS: begin
        rdMux[BIT_RDY] = flagReg[1];
        rdMux[BIT_CMP] = flagReg[0];
      end
      default: rdMux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            regRdata <= '0;
    else if (stb.rdAccess) regRdata <= rdMux;
  end

  assign dmaEnable  = startReg[1];
  assign sramCpuOwn = grantReg;
  assign irq        = |(flagReg & maskReg);
  assign jobDone    = &flagReg;

  // R7: a set flag stays set unless a clear write targets it
  p_flag_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (flagReg[0] && !(stb.wrFlags && regWdata[BIT_CMP])) |=> flagReg[0]);

  // R8: a set pulse wins over a clear in the same cycle
  p_set_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (loadDone && stb.wrFlags) |=> flagReg[1]);

endmodule

// File: rtl/modexp_csr.sv
module modexp_csr
  import modexp_csr_pkg::*;
#(
  parameter int SRC_W = 32,
  parameter int LEN_W = 16,
  parameter int OPL_W = 16
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              regValid,
  input  logic              regWe,
  input  logic [11:0]       regAddr,
  input  logic [31:0]       regWdata,
  output logic [31:0]       regRdata,
  output logic              regReady,
  output logic              engStart,
  output logic              loadStart,
  output logic              dmaEnable,
  output logic [1:0]        engMode,
  output logic [OPL_W-1:0]  expBits,
  output logic [OPL_W-1:0]  modBits,
  output logic [SRC_W-1:0]  dmaSrc,
  output logic [LEN_W-1:0]  dmaLen,
  input  logic              loadDone,
  input  logic              engDone,
  output logic              sramCpuOwn,
  output logic              sramEngOwn,
  output logic              irq,
  output logic              jobDone
);

  csrStrobeT stb;

  modexp_csr_ctrl u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .regValid   (regValid),
    .regWe      (regWe),
    .regAddr    (regAddr),
    .startBits  (regWdata[1:0]),
    .sramCpuOwn (sramCpuOwn),
    .stb        (stb),
    .regReady   (regReady),
    .engStart   (engStart),
    .loadStart  (loadStart)
  );

  modexp_csr_dp #(
    .SRC_W (SRC_W),
    .LEN_W (LEN_W),
    .OPL_W (OPL_W)
  ) u_dp (
    .clk        (clk),
    .rst_n      (rst_n),
    .stb        (stb),
    .regAddr    (regAddr),
    .regWdata   (regWdata),
    .loadDone   (loadDone),
    .engDone    (engDone),
    .regRdata   (regRdata),
    .dmaEnable  (dmaEnable),
    .engMode    (engMode),
    .expBits    (expBits),
    .modBits    (modBits),
    .dmaSrc     (dmaSrc),
    .dmaLen     (dmaLen),
    .sramCpuOwn (sramCpuOwn),
    .irq        (irq),
    .jobDone    (jobDone)
  );

  assign sramEngOwn = !sramCpuOwn;

  // R10: exactly one SRAM owner
  p_one_owner_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({sramCpuOwn, sramEngOwn}) == 1);

  // R11: the engine is never launched while the CPU holds the SRAM
  p_no_launch_granted_r11: assert property (@(posedge clk) disable iff (!rst_n)
    engStart |-> !sramCpuOwn);

  // R13: both flags set and both unmasked means an interrupt
  p_done_irq_r13: assert property (@(posedge clk) disable iff (!rst_n)
    (jobDone && $past(regValid && regWe && regAddr == OFF_MASK && regWdata[2] && regWdata[1]))
      |-> irq);

endmodule

// File: tb/modexp_csr_bench.sv
module modexp_csr_bench;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        regValid = 1'b0;
  logic        regWe = 1'b0;
  logic [11:0] regAddr = '0;
  logic [31:0] regWdata = '0;
  logic        loadDone = 1'b0;
  logic        engDone = 1'b0;
  logic [31:0] regRdata;
  logic        regReady, engStart, loadStart, dmaEnable;
  logic [1:0]  engMode;
  logic [15:0] expBits, modBits, dmaLen;
  logic [31:0] dmaSrc;
  logic        sramCpuOwn, sramEngOwn, irq, jobDone;

  always #(CLK_PERIOD/2) clk = ~clk;

  modexp_csr u_modexp_csr (
    .clk(clk), .rst_n(rst_n), .regValid(regValid), .regWe(regWe),
    .regAddr(regAddr), .regWdata(regWdata), .regRdata(regRdata),
    .regReady(regReady), .engStart(engStart), .loadStart(loadStart),
    .dmaEnable(dmaEnable), .engMode(engMode), .expBits(expBits),
    .modBits(modBits), .dmaSrc(dmaSrc), .dmaLen(dmaLen),
    .loadDone(loadDone), .engDone(engDone), .sramCpuOwn(sramCpuOwn),
    .sramEngOwn(sramEngOwn), .irq(irq), .jobDone(jobDone)
  );

  // behavioural reference state
  int unsigned mStart, mMode, mGrant, mSrc, mLen, mOpLen, mMask, mFlags;
  int unsigned mRdata;
  bit mReady, mEng, mLoad;
  int nCmp = 0, nBad = 0, nCyc = 0;
  string curReq = "R1";

  function automatic int unsigned refRead(input int unsigned a);
    case (a)
      'h000: return mStart;
      'h048: return (mGrant << 8) | (mMode << 4);
      'h04C: return mSrc;
      'h050: return mLen;
      'h058: return mOpLen;
      'h3F8: return mMask;
      'h3FC: return mFlags;
      default: return 0;
    endcase
  endfunction

  task automatic refStep();
    int unsigned d;
    bit wr;
    d = regWdata;
    wr = regValid && regWe;
    if (!rst_n) begin
      mStart = 0; mMode = 0; mGrant = 0; mSrc = 0; mLen = 0; mOpLen = 0;
      mMask = 0; mFlags = 0; mRdata = 0; mReady = 0; mEng = 0; mLoad = 0;
      return;
    end
    mEng   = wr && regAddr == 'h000 && d[0] && mGrant == 0;
    mLoad  = mEng && d[1];
    mReady = regValid;
    if (regValid && !regWe) mRdata = refRead(regAddr);
    if (wr) begin
      case (regAddr)
        'h000: mStart = d & 3;
        'h048: begin mGrant = (d >> 8) & 1; mMode = (d >> 4) & 3; end
        'h04C: mSrc = d;
        'h050: mLen = d & 'hFFFF;
        'h058: mOpLen = d;
        'h3F8: mMask = d & 6;
        'h3FC: mFlags = mFlags & ~(d & 6);
        default: ;
      endcase
    end
    if (loadDone) mFlags = mFlags | 4;
    if (engDone)  mFlags = mFlags | 2;
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp, input string what);
    string tag;
    tag = (curReq == "R1") ? "R1" : req;
    nCmp++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s %s: actual %h expected %h at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic compareAll();
    chk("R2", 32'(regReady), 32'(mReady), "regReady");
    chk(curReq, regRdata, mRdata, "regRdata");
    chk((curReq == "R11") ? "R11" : "R3", 32'(engStart), 32'(mEng), "engStart");
    chk((curReq == "R11") ? "R11" : "R3", 32'(loadStart), 32'(mLoad), "loadStart");
    chk("R3", 32'(dmaEnable), (mStart >> 1) & 1, "dmaEnable");
    chk("R4", 32'(engMode), mMode, "engMode");
    chk("R5", {expBits, modBits}, mOpLen, "opLen");
    chk("R6", dmaSrc, mSrc, "dmaSrc");
    chk("R6", 32'(dmaLen), mLen, "dmaLen");
    chk("R10", 32'(sramCpuOwn), mGrant, "sramCpuOwn");
    chk("R10", 32'(sramEngOwn), 32'(mGrant == 0), "sramEngOwn");
    chk("R9", 32'(irq), 32'((mFlags & mMask) != 0), "irq");
    chk("R13", 32'(jobDone), 32'(mFlags == 6), "jobDone");
  endtask

  task automatic cyc();
    @(posedge clk);
    refStep();
    @(negedge clk);
    compareAll();
    nCyc++;
  endtask

  task automatic idle();
    regValid = 0; regWe = 0; loadDone = 0; engDone = 0;
    cyc();
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d, input string req);
    curReq = req;
    regValid = 1; regWe = 1; regAddr = a; regWdata = d;
    cyc();
    regValid = 0; regWe = 0;
  endtask

  task automatic rd(input logic [11:0] a, input string req);
    curReq = req;
    regValid = 1; regWe = 0; regAddr = a;
    cyc();
    regValid = 0;
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * WATCHDOG);
    nBad++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    // R1: reset state
    curReq = "R1";
    repeat (3) cyc();
    rst_n = 1;
    rd(12'h000, "R1"); rd(12'h3FC, "R1"); rd(12'h058, "R1");
    idle();

    // R5, R6, R4: configuration writes and readback
    wr(12'h058, 32'h0011_0800, "R5"); rd(12'h058, "R5");
    wr(12'h04C, 32'hDEAD_BEE0, "R6"); rd(12'h04C, "R6");
    wr(12'h050, 32'hABCD_0600, "R6"); rd(12'h050, "R6");
    wr(12'h048, 32'h0000_0030, "R4"); rd(12'h048, "R4");
    wr(12'h048, 32'hFFFF_FFEF, "R4"); rd(12'h048, "R4");
    wr(12'h048, 32'h0000_0020, "R4"); rd(12'h048, "R4");
    wr(12'h048, 32'h0000_0030, "R4");

    // R3: DMA launch, then engine-only launch, then back-to-back
    wr(12'h000, 32'h0000_0003, "R3"); idle(); rd(12'h000, "R3");
    wr(12'h000, 32'h0000_0001, "R3"); idle();
    wr(12'h000, 32'h0000_0003, "R3"); wr(12'h000, 32'h0000_0003, "R3");
    wr(12'h000, 32'h0000_0002, "R3"); idle(); rd(12'h000, "R3");

    // R7, R9: loader done then engine done, mask enabling interrupt
    wr(12'h3F8, 32'h0000_0004, "R9"); rd(12'h3F8, "R9");
    curReq = "R7"; loadDone = 1; cyc(); loadDone = 0; idle();
    rd(12'h3FC, "R7");
    curReq = "R13"; engDone = 1; cyc(); engDone = 0; idle();
    rd(12'h3FC, "R13");
    wr(12'h3F8, 32'h0000_0002, "R9"); idle();

    // R8: write back the read value clears both
    wr(12'h3FC, 32'h0000_0006, "R8"); rd(12'h3FC, "R8");
    // R8: set wins over simultaneous clear; partial clear
    curReq = "R8"; loadDone = 1; engDone = 1; cyc(); loadDone = 0; engDone = 0;
    loadDone = 1; wr(12'h3FC, 32'h0000_0004, "R8"); loadDone = 0; rd(12'h3FC, "R8");
    wr(12'h3FC, 32'h0000_0002, "R8"); rd(12'h3FC, "R8");
    wr(12'h3FC, 32'h0000_0004, "R8"); rd(12'h3FC, "R8");

    // R10, R11: stop, hand SRAM to CPU, launch attempt ignored
    wr(12'h000, 32'h0, "R10");
    wr(12'h048, 32'h0000_0100, "R10"); idle(); rd(12'h048, "R10");
    wr(12'h000, 32'h0000_0003, "R11"); idle(); rd(12'h000, "R11");
    wr(12'h048, 32'h0000_0030, "R10");
    wr(12'h000, 32'h0000_0001, "R11"); idle();

    // R12: unmapped offsets
    wr(12'h044, 32'hFFFF_FFFF, "R12"); rd(12'h044, "R12");
    wr(12'h3F4, 32'hFFFF_FFFF, "R12"); rd(12'h3F4, "R12");
    wr(12'h004, 32'h0000_0003, "R12"); idle();
    rd(12'h058, "R12"); rd(12'h04C, "R12"); rd(12'h3FC, "R12");
    idle();

    summary();
  end

endmodule